// File: doc/BRIEF.md
# ADC Register Configuration Sequencer

This block brings a high-speed data converter from power-up into a working state without software. After reset it waits until the converter's sample clock is present. It then drives an active-high hardware reset pulse into the converter and waits a settling interval. Next it runs a fixed, ordered series of register writes through an existing serial write engine. The interface to that engine is a simple one: an address, a data byte, a one-cycle write strobe and a completion pulse.

The write series does five things. It issues a software reset. It selects a decimate-by-4 complex mode with two down-converters per channel. It loads the two 48-bit oscillator tuning words, taken from input ports, one byte at a time. It applies the tuning words with a set/clear strobe pair on the update register. It restricts the sync pulse to the down-converter and oscillator logic, and then fires the sync pulse with a second set/clear strobe pair. Both strobe pairs act on the 0-to-1 transition, so each keeps the set value for a programmable hold time (1 ms by default) before clearing it.

A `busy`/`done` pair reports progress. A pulse on `start` after completion runs the whole series again, starting from the hardware reset pulse.

Top module: `adc_cfg_seq`

## Requirements
- R1: `conv_rst` is high in a cycle only if `clk_present` was high in the previous cycle. While `clk_present` is low after reset, no reset pulse starts. If `clk_present` drops during the pulse, the pulse ends and restarts once the clock returns.
- R2: A completed reset pulse lasts exactly `RST_CYCLES` cycles. No write strobe occurs while `conv_rst` is high. The first write strobe comes at least `SETTLE_CYCLES` cycles after `conv_rst` falls.
- R3: `wr_strobe` is high for a single cycle per write. `wr_addr` and `wr_data` stay stable from the strobe until `wr_done`. No new strobe is issued while a write is outstanding.
- R4: The first write of every run is data 0x01 to address 0x100.
- R5: Writes 2 to 4 are, in this order, 0x02 to 0x169, 0x04 to 0x162 and 0x12 to 0x169, so 0x169 ends at 0x12.
- R6: Writes 5 to 10 store `nco0_word` byte k (bits 8k+7:8k) at address 0x200+k, for k from 0 to 5 ascending. Writes 11 to 16 store `nco1_word` byte k at 0x240+k in the same way.
- R7: Write 17 is 0x01 to 0x165 and write 18 is 0x00 to 0x165. The strobe of write 18 comes at least `HOLD_CYCLES` cycles after the completion of write 17.
- R8: Write 19 is 0x82 to 0x161, write 20 is 0x03 to 0x160 and write 21 is 0x00 to 0x160. The strobe of write 21 comes at least `HOLD_CYCLES` cycles after the completion of write 20.
- R9: A run issues exactly 21 writes. `done` rises in the cycle after the last completion and stays quiet on strobe and reset until restarted.
- R10: A `start` pulse while `done` is high runs the full series again, including a new reset pulse. A `start` while `busy` has no effect: there is no extra reset pulse and no extra write.
- R11: During and right after reset, `busy`=1, `done`=0, `conv_rst`=0 and `wr_strobe`=0. `busy` and `done` are always complementary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Re-run request, honoured only when finished |
| clk_present | input | 1 | Converter sample clock is running |
| nco0_word | input | NCO_W | Tuning word for down-converter 0 |
| nco1_word | input | NCO_W | Tuning word for down-converter 1 |
| conv_rst | output | 1 | Active-high hardware reset to the converter |
| wr_addr | output | 12 | Register address to the write engine |
| wr_data | output | 8 | Register data to the write engine |
| wr_strobe | output | 1 | One-cycle write request |
| wr_done | input | 1 | One-cycle completion from the write engine |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence complete |

## Verification
The checker assumes three things about the write engine:
- it raises `wr_done` once per accepted strobe;
- it raises `wr_done` no earlier than the cycle of that strobe;
- it never raises `wr_done` when no write is pending.

The checker also assumes that `clk_present` and `start` are synchronous to `clk`. The bench engine model keeps within these assumptions. It pulses completion exactly once per strobe, after a random latency of 1 to 4 cycles. All bench inputs change half a cycle or one step away from the sampling edge. The tuning words change only while the block is finished.

// File: rtl/adc_cfg_pkg.sv
package adc_cfg_pkg;

    localparam int REG_ADDR_W = 12;
    localparam int REG_DATA_W = 8;

    localparam int MODE_STEPS = 4;
    localparam int TAIL_STEPS = 5;

    localparam logic [REG_ADDR_W-1:0] A_SOFT_RST   = 12'h100;
    localparam logic [REG_ADDR_W-1:0] A_DEC_CTRL   = 12'h169;
    localparam logic [REG_ADDR_W-1:0] A_CPLX_CTRL  = 12'h162;
    localparam logic [REG_ADDR_W-1:0] A_NCO_UPD    = 12'h165;
    localparam logic [REG_ADDR_W-1:0] A_SYNC_MASK  = 12'h161;
    localparam logic [REG_ADDR_W-1:0] A_SYNC_PULSE = 12'h160;
    localparam int NCO0_BASE = 'h200;
    localparam int NCO1_BASE = 'h240;

    typedef enum logic [2:0] {
        ST_WAIT_CLK,
        ST_RST_PULSE,
        ST_SETTLE,
        ST_ISSUE,
        ST_WAIT_DONE,
        ST_HOLD,
        ST_FINISH
    } seq_state_e;

    typedef struct packed {
        logic [REG_ADDR_W-1:0] addr;
        logic [REG_DATA_W-1:0] data;
    } reg_write_t;

endpackage

// File: rtl/adc_cfg_timer.sv
module adc_cfg_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/adc_cfg_step_rom.sv
module adc_cfg_step_rom
    import adc_cfg_pkg::*;
#(
    parameter int NCO_W  = 48,
    parameter int STEP_W = 5
) (
    input  logic [STEP_W-1:0] step,
    input  logic [NCO_W-1:0]  nco0_word,
    input  logic [NCO_W-1:0]  nco1_word,
    output reg_write_t        wr,
    output logic              hold_after,
    output logic              last_step
);

    localparam int NCO_BYTES = NCO_W / 8;
    localparam int BYTE_IW   = (NCO_BYTES > 1) ? $clog2(NCO_BYTES) : 1;
    localparam int NCO0_LO   = MODE_STEPS;
    localparam int NCO1_LO   = MODE_STEPS + NCO_BYTES;
    localparam int TAIL_LO   = MODE_STEPS + 2 * NCO_BYTES;
    localparam int NUM_STEPS = TAIL_LO + TAIL_STEPS;

    logic [7:0] nco0_b [NCO_BYTES];
    logic [7:0] nco1_b [NCO_BYTES];

    for (genvar k = 0; k < NCO_BYTES; k++) begin : g_split
        assign nco0_b[k] = nco0_word[8*k +: 8];
        assign nco1_b[k] = nco1_word[8*k +: 8];
    end

    int               idx;
    logic [BYTE_IW-1:0] off;

    always_comb begin
        idx        = int'(step);
        off        = '0;
        wr         = '{addr: A_SOFT_RST, data: 8'h01};
        hold_after = 1'b0;
        last_step  = (idx == NUM_STEPS - 1);
        if (idx < NCO0_LO) begin
            case (idx)
                1:       wr = '{addr: A_DEC_CTRL,  data: 8'h02};
                2:       wr = '{addr: A_CPLX_CTRL, data: 8'h04};
                3:       wr = '{addr: A_DEC_CTRL,  data: 8'h12};
                default: wr = '{addr: A_SOFT_RST,  data: 8'h01};
            endcase
        end else if (idx < NCO1_LO) begin
            off     = BYTE_IW'(idx - NCO0_LO);
            wr.addr = REG_ADDR_W'(NCO0_BASE + idx - NCO0_LO);
            wr.data = nco0_b[off];
        end else if (idx < TAIL_LO) begin
            off     = BYTE_IW'(idx - NCO1_LO);
            wr.addr = REG_ADDR_W'(NCO1_BASE + idx - NCO1_LO);
            wr.data = nco1_b[off];
        end else begin
            case (idx - TAIL_LO)
                0:       wr = '{addr: A_NCO_UPD,    data: 8'h01};
                1:       wr = '{addr: A_NCO_UPD,    data: 8'h00};
                2:       wr = '{addr: A_SYNC_MASK,  data: 8'h82};
                3:       wr = '{addr: A_SYNC_PULSE, data: 8'h03};
                default: wr = '{addr: A_SYNC_PULSE, data: 8'h00};
            endcase
            hold_after = (idx == TAIL_LO) || (idx == TAIL_LO + 3);
        end
    end

endmodule

// File: rtl/adc_cfg_seq.sv
module adc_cfg_seq
    import adc_cfg_pkg::*;
#(
    parameter int NCO_W         = 48,
    parameter int CLK_FREQ_HZ   = 50_000_000,
    parameter int RST_CYCLES    = 16,
    parameter int SETTLE_CYCLES = 256,
    parameter int HOLD_CYCLES   = CLK_FREQ_HZ / 1000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  clk_present,
    input  logic [NCO_W-1:0]      nco0_word,
    input  logic [NCO_W-1:0]      nco1_word,
    output logic                  conv_rst,
    output logic [REG_ADDR_W-1:0] wr_addr,
    output logic [REG_DATA_W-1:0] wr_data,
    output logic                  wr_strobe,
    input  logic                  wr_done,
    output logic                  busy,
    output logic                  done
);

    localparam int NCO_BYTES = NCO_W / 8;
    localparam int NUM_STEPS = MODE_STEPS + 2 * NCO_BYTES + TAIL_STEPS;
    localparam int STEP_W    = $clog2(NUM_STEPS);
    localparam int CNT_MAX_A = (RST_CYCLES > SETTLE_CYCLES) ? RST_CYCLES : SETTLE_CYCLES;
    localparam int CNT_MAX   = (CNT_MAX_A > HOLD_CYCLES) ? CNT_MAX_A : HOLD_CYCLES;
    localparam int CNT_W     = $clog2(CNT_MAX + 1);

    typedef struct packed {
        seq_state_e            st;
        logic [STEP_W-1:0]     step;
        logic [REG_ADDR_W-1:0] addr;
        logic [REG_DATA_W-1:0] data;
        logic                  strobe;
        logic                  conv_rst;
        logic                  busy;
        logic                  done;
    } seq_regs_t;

    seq_regs_t         q, n;
    reg_write_t        rom_wr;
    logic              rom_hold, rom_last;
    logic              tmr_load, tmr_expired;
    logic [CNT_W-1:0]  tmr_val;

    adc_cfg_step_rom #(
        .NCO_W  (NCO_W),
        .STEP_W (STEP_W)
    ) u_rom (
        .step       (q.step),
        .nco0_word  (nco0_word),
        .nco1_word  (nco1_word),
        .wr         (rom_wr),
        .hold_after (rom_hold),
        .last_step  (rom_last)
    );

    adc_cfg_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    always_comb begin
        n        = q;
        n.strobe = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (q.st)
            ST_WAIT_CLK: begin
                if (clk_present) begin
                    n.st     = ST_RST_PULSE;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(RST_CYCLES - 1);
                end
            end
            ST_RST_PULSE: begin
                if (!clk_present) begin
                    n.st = ST_WAIT_CLK;
                end else if (tmr_expired) begin
                    n.st     = ST_SETTLE;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(SETTLE_CYCLES - 1);
                end
            end
            ST_SETTLE: begin
                if (tmr_expired) begin
                    n.st = ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                n.addr   = rom_wr.addr;
                n.data   = rom_wr.data;
                n.strobe = 1'b1;
                n.st     = ST_WAIT_DONE;
            end
            ST_WAIT_DONE: begin
                if (wr_done) begin
                    if (rom_last) begin
                        n.st = ST_FINISH;
                    end else begin
                        n.step = q.step + 1'b1;
                        if (rom_hold) begin
                            n.st     = ST_HOLD;
                            tmr_load = 1'b1;
                            tmr_val  = CNT_W'(HOLD_CYCLES - 1);
                        end else begin
                            n.st = ST_ISSUE;
                        end
                    end
                end
            end
            ST_HOLD: begin
                if (tmr_expired) begin
                    n.st = ST_ISSUE;
                end
            end
            ST_FINISH: begin
                if (start) begin
                    n.st   = ST_WAIT_CLK;
                    n.step = '0;
                end
            end
            default: n.st = ST_WAIT_CLK;
        endcase
        n.conv_rst = (n.st == ST_RST_PULSE);
        n.done     = (n.st == ST_FINISH);
        n.busy     = (n.st != ST_FINISH);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st       <= ST_WAIT_CLK;
            q.step     <= '0;
            q.addr     <= '0;
            q.data     <= '0;
            q.strobe   <= 1'b0;
            q.conv_rst <= 1'b0;
            q.busy     <= 1'b1;
            q.done     <= 1'b0;
        end else begin
            q <= n;
        end
    end

    assign conv_rst  = q.conv_rst;
    assign wr_addr   = q.addr;
    assign wr_data   = q.data;
    assign wr_strobe = q.strobe;
    assign busy      = q.busy;
    assign done      = q.done;

endmodule

// File: rtl/adc_cfg_seq_chk.sv
module adc_cfg_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        clk_present,
    input logic        conv_rst,
    input logic [11:0] wr_addr,
    input logic [7:0]  wr_data,
    input logic        wr_strobe,
    input logic        wr_done,
    input logic        done
);

    logic pending_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending_q <= 1'b0;
        end else if (wr_strobe && !wr_done) begin
            pending_q <= 1'b1;
        end else if (wr_done) begin
            pending_q <= 1'b0;
        end
    end

    AST_RST_NEEDS_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        conv_rst |-> $past(clk_present)); // R1

    AST_NO_WRITE_IN_RST: assert property (@(posedge clk) disable iff (!rst_n)
        conv_rst |-> !wr_strobe); // R2

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe |=> !wr_strobe); // R3

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe |-> !pending_q); // R3

    AST_HOLD_ADDR_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_q && !wr_strobe) |-> ($stable(wr_addr) && $stable(wr_data))); // R3

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!wr_strobe && !conv_rst)); // R9

    AST_DONE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(wr_done)); // R9

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done); // R10

endmodule

bind adc_cfg_seq adc_cfg_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .clk_present (clk_present),
    .conv_rst    (conv_rst),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .wr_strobe   (wr_strobe),
    .wr_done     (wr_done),
    .done        (done)
);

// File: tb/adc_cfg_seq_bench.sv
`timescale 1ns/1ps
module adc_cfg_seq_bench;

    localparam int RSTC   = 4;
    localparam int SETTLE = 8;
    localparam int HOLD   = 20;
    localparam int NSTEPS = 21;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        clk_present = 1'b0;
    logic [47:0] nco0_word = 48'h2353F7CED916;
    logic [47:0] nco1_word = 48'h23D70A3D70A3;
    logic        conv_rst;
    logic [11:0] wr_addr;
    logic [7:0]  wr_data;
    logic        wr_strobe;
    logic        wr_done = 1'b0;
    logic        busy, done;

    always #10 clk = ~clk;

    adc_cfg_seq #(
        .NCO_W         (48),
        .CLK_FREQ_HZ   (50_000_000),
        .RST_CYCLES    (RSTC),
        .SETTLE_CYCLES (SETTLE),
        .HOLD_CYCLES   (HOLD)
    ) u_adc_cfg_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .clk_present (clk_present),
        .nco0_word   (nco0_word),
        .nco1_word   (nco1_word),
        .conv_rst    (conv_rst),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .wr_strobe   (wr_strobe),
        .wr_done     (wr_done),
        .busy        (busy),
        .done        (done)
    );

    int n_checks = 0;
    int n_fail   = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Write-engine model and port monitor, all on the falling edge
    logic [7:0]  regf [0:1023];
    logic [11:0] log_addr [0:63];
    logic [7:0]  log_data [0:63];
    int          strobe_cyc [0:63];
    int          done_cyc [0:63];
    int          log_n = 0;
    int          cyc = 0;
    int          lat = 0;
    logic [11:0] held_addr;
    logic [7:0]  held_data;
    int          overlap_err = 0;
    int          hold_err = 0;
    int          multi_strobe_err = 0;
    logic        prev_strobe = 1'b0;
    logic        prev_clk_p = 1'b0;
    int          rst_run = 0;
    int          last_rst_len = 0;
    int          rst_rises = 0;
    int          rst_fall_cyc = 0;
    int          bad_rst = 0;
    int          strobe_in_rst = 0;

    always @(negedge clk) begin
        cyc++;
        wr_done = 1'b0;
        if (lat != 0) begin
            if (wr_addr != held_addr || wr_data != held_data) hold_err++;
            if (lat == 1) begin
                wr_done = 1'b1;
                done_cyc[log_n-1] = cyc;
            end
            lat--;
        end
        if (wr_strobe === 1'b1) begin
            if (lat != 0) overlap_err++;
            if (prev_strobe) multi_strobe_err++;
            if (conv_rst === 1'b1) strobe_in_rst++;
            if (log_n < 64) begin
                log_addr[log_n]   = wr_addr;
                log_data[log_n]   = wr_data;
                strobe_cyc[log_n] = cyc;
            end
            log_n++;
            held_addr = wr_addr;
            held_data = wr_data;
            regf[wr_addr[9:0]] = wr_data;
            lat = 1 + int'($urandom % 4);
        end
        prev_strobe = (wr_strobe === 1'b1);
        if (conv_rst === 1'b1) begin
            if (!prev_clk_p) bad_rst++;
            if (rst_run == 0) rst_rises++;
            rst_run++;
        end else if (rst_run != 0) begin
            last_rst_len = rst_run;
            rst_fall_cyc = cyc;
            rst_run      = 0;
        end
        prev_clk_p = clk_present;
    end

    function automatic logic [19:0] exp_step(input int i, input logic [47:0] w0,
                                             input logic [47:0] w1);
        if (i >= 4 && i < 10)  return {12'(32'h200 + i - 4),  w0[8*(i-4) +: 8]};
        if (i >= 10 && i < 16) return {12'(32'h240 + i - 10), w1[8*(i-10) +: 8]};
        case (i)
            0:  return {12'h100, 8'h01};
            1:  return {12'h169, 8'h02};
            2:  return {12'h162, 8'h04};
            3:  return {12'h169, 8'h12};
            16: return {12'h165, 8'h01};
            17: return {12'h165, 8'h00};
            18: return {12'h161, 8'h82};
            19: return {12'h160, 8'h03};
            default: return {12'h160, 8'h00};
        endcase
    endfunction

    task automatic clear_logs();
        log_n = 0; overlap_err = 0; hold_err = 0; multi_strobe_err = 0;
        rst_rises = 0; bad_rst = 0; strobe_in_rst = 0;
        for (int a = 0; a < 1024; a++) regf[a] = 8'h5A;
    endtask

    task automatic wait_done(input bit mid_start);
        int  guard = 0;
        bit  fired = 0;
        while (done !== 1'b1 && guard < 20000) begin
            @(negedge clk);
            guard++;
            if (mid_start && !fired && log_n == 6) begin
                start = 1'b1;
                @(negedge clk);
                start = 1'b0;
                fired = 1;
            end
        end
        chk(guard < 20000, "R9", "watchdog: run did not finish", guard, 20000);
        @(negedge clk);
    endtask

    task automatic check_run(input logic [47:0] w0, input logic [47:0] w1,
                             input int exp_rises);
        logic [19:0] e;
        chk(log_n == NSTEPS, "R9", "write count", log_n, NSTEPS);
        for (int i = 0; i < NSTEPS; i++) begin
            e = exp_step(i, w0, w1);
            chk(log_addr[i] == e[19:8],
                (i == 0) ? "R4" : (i < 4) ? "R5" : (i < 16) ? "R6" : (i < 18) ? "R7" : "R8",
                $sformatf("addr of write %0d", i), log_addr[i], e[19:8]);
            chk(log_data[i] == e[7:0],
                (i == 0) ? "R4" : (i < 4) ? "R5" : (i < 16) ? "R6" : (i < 18) ? "R7" : "R8",
                $sformatf("data of write %0d", i), log_data[i], e[7:0]);
        end
        chk(regf[10'h169] == 8'h12, "R5", "final 0x169", regf[10'h169], 8'h12);
        chk(regf[10'h162] == 8'h04, "R5", "final 0x162", regf[10'h162], 8'h04);
        for (int k = 0; k < 6; k++) begin
            chk(regf[10'h200 + k] == w0[8*k +: 8], "R6", "ddc0 byte",
                regf[10'h200 + k], w0[8*k +: 8]);
            chk(regf[10'h240 + k] == w1[8*k +: 8], "R6", "ddc1 byte",
                regf[10'h240 + k], w1[8*k +: 8]);
        end
        chk(regf[10'h165] == 8'h00, "R7", "final 0x165", regf[10'h165], 0);
        chk(strobe_cyc[17] - done_cyc[16] >= HOLD, "R7", "update hold spacing",
            strobe_cyc[17] - done_cyc[16], HOLD);
        chk(regf[10'h161] == 8'h82, "R8", "final 0x161", regf[10'h161], 8'h82);
        chk(regf[10'h160] == 8'h00, "R8", "final 0x160", regf[10'h160], 0);
        chk(strobe_cyc[20] - done_cyc[19] >= HOLD, "R8", "sync hold spacing",
            strobe_cyc[20] - done_cyc[19], HOLD);
        chk(last_rst_len == RSTC, "R2", "reset pulse width", last_rst_len, RSTC);
        chk(strobe_cyc[0] - rst_fall_cyc >= SETTLE, "R2", "settle before first write",
            strobe_cyc[0] - rst_fall_cyc, SETTLE);
        chk(strobe_in_rst == 0, "R2", "strobes during reset", strobe_in_rst, 0);
        chk(bad_rst == 0, "R1", "reset without clock", bad_rst, 0);
        chk(overlap_err == 0, "R3", "overlapping writes", overlap_err, 0);
        chk(hold_err == 0, "R3", "addr/data changed while pending", hold_err, 0);
        chk(multi_strobe_err == 0, "R3", "multi-cycle strobe", multi_strobe_err, 0);
        chk(rst_rises == exp_rises, "R10", "reset pulses in run", rst_rises, exp_rises);
        chk(done == 1'b1 && busy == 1'b0, "R11", "done/busy at end", {busy, done}, 2'b01);
    endtask

    task automatic rerun(input logic [47:0] w0, input logic [47:0] w1,
                         input bit mid_start);
        int guard = 0;
        @(posedge clk); #1;
        nco0_word = w0;
        nco1_word = w1;
        clear_logs();
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        while (busy !== 1'b1 && guard < 10) begin
            @(negedge clk);
            guard++;
        end
        chk(busy == 1'b1, "R10", "start after done restarts", busy, 1);
        wait_done(mid_start);
        check_run(w0, w1, 1);
    endtask

    initial begin
        clear_logs();
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(conv_rst == 1'b0, "R11", "reset: conv_rst", conv_rst, 0);
        chk(wr_strobe == 1'b0, "R11", "reset: wr_strobe", wr_strobe, 0);
        chk(busy == 1'b1, "R11", "reset: busy", busy, 1);
        chk(done == 1'b0, "R11", "reset: done", done, 0);
        @(posedge clk); #1;
        rst_n = 1'b1;

        // Clock absent: no pulse may start
        repeat (30) @(negedge clk);
        chk(rst_rises == 0, "R1", "pulse with clock absent", rst_rises, 0);
        chk(log_n == 0, "R1", "writes with clock absent", log_n, 0);

        // Clock appears, drops mid-pulse, then returns
        @(posedge clk); #1;
        clk_present = 1'b1;
        repeat (2) @(negedge clk);
        @(posedge clk); #1;
        clk_present = 1'b0;
        repeat (5) @(negedge clk);
        chk(conv_rst == 1'b0, "R1", "pulse ends when clock drops", conv_rst, 0);
        @(posedge clk); #1;
        clk_present = 1'b1;
        wait_done(1'b0);
        check_run(48'h2353F7CED916, 48'h23D70A3D70A3, 2);

        rerun(48'hFFFFFFFFFFFF, 48'h000000000000, 1'b0);
        rerun(48'h0123456789AB, 48'hBA9876543210, 1'b1);  // R10: start while busy
        rerun(48'h800000000001, 48'h7FFFFFFFFFFE, 1'b0);
        rerun({$urandom, 16'hC35A}, {16'h1E2D, $urandom}, 1'b1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #3_000_000;
        n_checks++;
        n_fail++;
        $display("FAIL R9 global watchdog: actual %0d expected below %0d", cyc, 150000);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule